// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns frames on an asynchronous serial line into parallel characters. A start bit is found on a falling edge of the idle-high line. The block then samples each data, parity and stop bit in the middle of its bit period. The bit period is counted in ticks of an oversampling strobe that comes from outside, so the baud generator sits elsewhere. Five control pins set the frame format: parity on or off, even or odd parity, least- or most-significant bit first, 7 or 8 data bits, and 1 or 2 stop bits.

Each accepted character goes into a holding buffer and raises a full flag. The framing, parity and overrun flags are sticky, and a summary flag is the OR of the three. One pulse on the read strobe clears the full flag and all error flags together. Two policy pins decide whether a character with errors, or a break, still reaches the buffer and raises the full flag. A rejected character still records its error flags.

Top module: `uart_rx_status`

## Requirements
- R1: A falling edge on the idle line starts a frame. The line is checked again half a bit period later. If it is high then, the start is dropped: no character is produced and busy returns low.
- R2: Data bits are taken at mid-bit. The byte is rebuilt LSB-first when the bit-order pin is 0 and MSB-first when it is 1. The seven-bit pin set to 1 selects 7 data bits, and bit 7 of the output is then 0.
- R3: With the two-stop pin set to 1, only the first stop bit is checked. A low second stop bit causes no error.
- R4: An accepted character is loaded into the buffer and sets the full flag. The buffer data does not change in any other cycle.
- R5: A low first stop bit sets the framing flag.
- R6: When parity is enabled and the received parity bit is wrong, the parity flag is set. Parity is even when the parity-select pin is 1 (data ones plus parity bit is even) and odd when it is 0. The flag never sets while parity is disabled.
- R7: The overrun flag is set when a character is loaded while the full flag is still set and no read happens in that cycle.
- R8: The summary error flag equals the OR of the framing, parity and overrun flags.
- R9: A read strobe clears the full flag and all four error flags. If a character is loaded in the same cycle, the new character and only its own errors remain.
- R10: With the error-accept pin at 0, a character with a framing or parity error is not loaded and leaves the full flag unchanged. With the pin at 1, the character is loaded.
- R11: A break is a frame whose data bits, parity bit (when enabled) and first stop bit are all 0. It is loaded only when the break-accept pin is 1, whatever the error-accept pin says.
- R12: Busy is high from start detection until the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| sample_tick | input | 1 | Oversampling strobe, OVS per bit period |
| cfg_par_en | input | 1 | 1 enables a parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 odd |
| cfg_msb_first | input | 1 | 1 means MSB is sent first |
| cfg_seven | input | 1 | 1 selects 7 data bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_err_accept | input | 1 | 1 loads characters with errors |
| cfg_brk_accept | input | 1 | 1 loads break characters |
| buf_rd | input | 1 | Buffer read strobe, clears flags |
| buf_data | output | 8 | Received character |
| buf_full | output | 1 | Unread character present |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_any | output | 1 | Summary of the three error flags |
| busy | output | 1 | Frame reception in progress |

## Verification
The case that matters is a buffer read that lands on the same clock edge as a character load. The bench first times one frame from a fixed tick phase to find the cycle in which the full flag rises. It then leaves an unread character with a parity error in the buffer and sends the same frame again, with the read strobe pulsed in exactly that cycle. The expected result is a full buffer holding the new character, with no overrun and with the old parity error cleared.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              par_err;
        logic              brk;
    } rx_result_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s,
    input  logic       tick,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       msb_first,
    input  logic       seven_bit,
    input  logic       two_stop,
    output logic       busy,
    output logic       done,
    output rx_result_t result
);
    localparam int PH_W  = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(OVS / 2 - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [PH_W-1:0]   ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              prev;
    } frame_t;

    frame_t q, d;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-1:0] asm_data;
    logic              mid;

    always_comb begin
        d        = q;
        done     = 1'b0;
        d.prev   = rx_s;
        last_idx = seven_bit ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);
        asm_data = (seven_bit && !msb_first) ? (q.sh >> 1) : q.sh;
        mid      = tick && (q.ph == PH_LAST);

        result.data      = asm_data;
        result.par_err   = par_en & (^asm_data ^ q.pbit ^ ~par_even);
        result.frame_err = ~rx_s;
        result.brk       = (asm_data == '0) & ~rx_s & (~par_en | ~q.pbit);

        if (tick && !mid) d.ph = q.ph + 1'b1;
        if (mid) d.ph = '0;

        unique case (q.state)
            RX_IDLE: begin
                d.ph = '0;
                if (q.prev && !rx_s) begin
                    d.state = RX_START;
                    d.sh    = '0;
                end
            end
            RX_START: begin
                if (tick && q.ph == PH_HALF) begin
                    d.ph  = '0;
                    d.cnt = '0;
                    d.state = rx_s ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (mid) begin
                    d.sh = msb_first ? {q.sh[DATA_W-2:0], rx_s}
                                     : {rx_s, q.sh[DATA_W-1:1]};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == last_idx) d.state = par_en ? RX_PAR : RX_STOP;
                end
            end
            RX_PAR: begin
                if (mid) begin
                    d.pbit  = rx_s;
                    d.state = RX_STOP;
                end
            end
            RX_STOP: begin
                if (mid) begin
                    done    = 1'b1;
                    d.state = two_stop ? RX_STOP2 : RX_IDLE;
                end
            end
            RX_STOP2: begin
                if (mid) d.state = RX_IDLE;
            end
            default: d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= RX_IDLE;
            q.ph    <= '0;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.pbit  <= 1'b0;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != RX_IDLE);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_result_t        result,
    input  logic              err_accept,
    input  logic              brk_accept,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              fe,
    output logic              pe,
    output logic              oe,
    output logic              any
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              fe;
        logic              pe;
        logic              oe;
        logic              any;
    } buf_t;

    buf_t q, d;
    logic accept;

    always_comb begin
        d = q;
        if (rd) begin
            d.full = 1'b0;
            d.fe   = 1'b0;
            d.pe   = 1'b0;
            d.oe   = 1'b0;
        end
        if (result.brk)
            accept = brk_accept;
        else if (result.frame_err || result.par_err)
            accept = err_accept;
        else
            accept = 1'b1;
        if (done) begin
            d.fe = d.fe | result.frame_err;
            d.pe = d.pe | result.par_err;
            if (accept) begin
                d.data = result.data;
                d.full = 1'b1;
                d.oe   = d.oe | (q.full & ~rd);
            end
        end
        d.any = d.fe | d.pe | d.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data = q.data;
    assign full = q.full;
    assign fe   = q.fe;
    assign pe   = q.pe;
    assign oe   = q.oe;
    assign any  = q.any;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              sample_tick,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_msb_first,
    input  logic              cfg_seven,
    input  logic              cfg_two_stop,
    input  logic              cfg_err_accept,
    input  logic              cfg_brk_accept,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_full,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_any,
    output logic              busy
);
    logic       rx_s;
    logic       frame_done;
    rx_result_t frame_res;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_s     (rx_s),
        .tick     (sample_tick),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .msb_first(cfg_msb_first),
        .seven_bit(cfg_seven),
        .two_stop (cfg_two_stop),
        .busy     (busy),
        .done     (frame_done),
        .result   (frame_res)
    );

    uart_rx_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frame_done),
        .result    (frame_res),
        .err_accept(cfg_err_accept),
        .brk_accept(cfg_brk_accept),
        .rd        (buf_rd),
        .data      (buf_data),
        .full      (buf_full),
        .fe        (err_frame),
        .pe        (err_parity),
        .oe        (err_overrun),
        .any       (err_any)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_par_en,
    input logic       buf_rd,
    input logic       frame_done,
    input logic [7:0] buf_data,
    input logic       buf_full,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       err_any,
    input logic       busy
);
    // R8
    summary_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_any == (err_frame | err_parity | err_overrun));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !frame_done) |=> (!buf_full && !err_any));

    // R7
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(buf_full));

    // R6
    par_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> $past(cfg_par_en));

    // R12
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> $past(busy));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(buf_data));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_par_en (cfg_par_en),
    .buf_rd     (buf_rd),
    .frame_done (frame_done),
    .buf_data   (buf_data),
    .buf_full   (buf_full),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_overrun(err_overrun),
    .err_any    (err_any),
    .busy       (busy)
);

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 8;
    localparam int BITC       = OVS * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic sample_tick = 1'b0;
    logic cfg_par_en = 0, cfg_par_even = 0, cfg_msb_first = 0, cfg_seven = 0;
    logic cfg_two_stop = 0, cfg_err_accept = 0, cfg_brk_accept = 0, buf_rd = 0;
    logic [7:0] buf_data;
    logic buf_full, err_frame, err_parity, err_overrun, err_any, busy;

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] e_data = 8'h00;
    logic e_full = 0, e_fe = 0, e_pe = 0, e_oe = 0;

    uart_rx_status #(.OVS(OVS), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample_tick(sample_tick),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_msb_first(cfg_msb_first), .cfg_seven(cfg_seven),
        .cfg_two_stop(cfg_two_stop), .cfg_err_accept(cfg_err_accept),
        .cfg_brk_accept(cfg_brk_accept), .buf_rd(buf_rd),
        .buf_data(buf_data), .buf_full(buf_full), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_any(err_any),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) sample_tick <= ~sample_tick;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "buf_data", buf_data, e_data);
        chk(req, "buf_full", buf_full, e_full);
        chk(req, "err_frame", err_frame, e_fe);
        chk(req, "err_parity", err_parity, e_pe);
        chk(req, "err_overrun", err_overrun, e_oe);
        chk(req, "err_any", err_any, e_fe | e_pe | e_oe);
        chk(req, "busy", busy, 0);
    endtask

    task automatic do_read();
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        @(negedge clk);
        e_full = 0; e_fe = 0; e_pe = 0; e_oe = 0;
    endtask

    task automatic bitout(input logic v);
        rx_line = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop1, input bit stop2);
        int n;
        logic [7:0] dm;
        logic p, fe, pe, brk, acc;
        n  = cfg_seven ? 7 : 8;
        dm = cfg_seven ? (d & 8'h7F) : d;
        p  = (cfg_par_even ? ^dm : ~^dm) ^ bad_par;
        bitout(1'b0);
        chk("R12", "busy mid-frame", busy, 1);
        for (int i = 0; i < n; i++) bitout(dm[cfg_msb_first ? (n - 1 - i) : i]);
        if (cfg_par_en) bitout(p);
        bitout(stop1);
        if (cfg_two_stop) bitout(stop2);
        bitout(1'b1);
        fe  = !stop1;
        pe  = cfg_par_en && bad_par;
        brk = (dm == 0) && !stop1 && (!cfg_par_en || !p);
        acc = brk ? cfg_brk_accept : ((fe || pe) ? cfg_err_accept : 1'b1);
        e_fe = e_fe | fe;
        e_pe = e_pe | pe;
        if (acc) begin
            e_oe   = e_oe | e_full;
            e_full = 1;
            e_data = dm;
        end
    endtask

    task automatic set_fmt(input logic pe, input logic ev, input logic m, input logic s, input logic t);
        cfg_par_en = pe; cfg_par_even = ev; cfg_msb_first = m; cfg_seven = s; cfg_two_stop = t;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        int t0, t1, off;
        pats = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R4");

        // R2 format sweep, R9 clear after read
        for (int c = 0; c < 32; c++) begin
            set_fmt(c[0], c[1], c[2], c[3], c[4]);
            for (int k = 0; k < 4; k++) begin
                send(pats[k], 0, 1, 1);
                check_state("R2");
                do_read();
                check_state("R9");
            end
        end

        // R3 second stop low is ignored
        set_fmt(0, 0, 0, 0, 1);
        send(8'h96, 0, 1, 0);
        check_state("R3");
        do_read();

        // R6 and R10 bad parity, reject then accept
        set_fmt(1, 1, 0, 0, 0);
        cfg_err_accept = 0;
        send(8'h55, 1, 1, 1);
        check_state("R10");
        do_read();
        set_fmt(1, 0, 1, 1, 0);
        cfg_err_accept = 1;
        send(8'h2B, 1, 1, 1);
        check_state("R6");
        do_read();

        // R5 framing error
        set_fmt(0, 0, 0, 0, 0);
        send(8'h4D, 0, 0, 1);
        check_state("R5");
        do_read();

        // R7 and R8 overrun
        cfg_err_accept = 0;
        send(8'h11, 0, 1, 1);
        send(8'h22, 0, 1, 1);
        check_state("R7");
        chk("R8", "err_any on overrun", err_any, 1);
        do_read();
        check_state("R9");

        // R11 break policy
        cfg_err_accept = 1; cfg_brk_accept = 0;
        send(8'h00, 0, 0, 1);
        check_state("R11");
        do_read();
        cfg_err_accept = 0; cfg_brk_accept = 1;
        set_fmt(1, 1, 0, 0, 0);
        send(8'h00, 0, 0, 1);
        check_state("R11");
        do_read();

        // R1 false start
        set_fmt(0, 0, 0, 0, 0);
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        chk("R12", "busy after edge", busy, 1);
        repeat (2 * BITC) @(negedge clk);
        check_state("R1");

        // R9 read and load in the same cycle
        while (cyc % 2 != 0) @(negedge clk);
        t0 = cyc; t1 = cyc;
        fork
            send(8'h5A, 0, 1, 1);
            begin
                while (!buf_full) @(negedge clk);
                t1 = cyc;
            end
        join
        off = t1 - t0;
        check_state("R4");
        cfg_err_accept = 1;
        cfg_par_en = 1;
        send(8'h33, 1, 1, 1);
        check_state("R6");
        cfg_par_en = 0;
        while (cyc % 2 != 0) @(negedge clk);
        t0 = cyc;
        fork
            send(8'h5A, 0, 1, 1);
            begin
                while (cyc != t0 + off - 1) @(negedge clk);
                buf_rd = 1'b1;
                @(negedge clk);
                buf_rd = 1'b0;
            end
        join
        e_full = 1; e_data = 8'h5A; e_fe = 0; e_pe = 0; e_oe = 0;
        check_state("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule